// File: doc/BRIEF.md
# State Controller with Unreachable-Code Test Loader

This block is a small finite-state controller whose state register has a second load source used only in test. A combinational next-state and output section drives the register in normal operation. In front of the register sits a two-way selector. One side takes the normal next state. The other side takes the code from a tiny sequencer that steps through the state encodings no input sequence can reach from reset. Test patterns that need those codes as present state can therefore be applied at full clock rate, with no scan chain and with the functional logic untouched.

A hold control freezes the register, so several input values can be applied against one present state. The present state is always visible on an observation bus. An optional single-bit parity of that bus serves designs that are short of output pins.

Top module: `ctl_dft_top`

## Requirements
- R1: An active-low asynchronous reset puts the state register at code 0 and restarts the test sequencer at its first entry, whatever the present state is.
- R2: With `tmode`=0 and `hold`=0, each rising clock loads the normal next state:
  - 0→(pin[0]?1:0)
  - 1→(pin[1]?2:3)
  - 2→4
  - 3→(pin[0]?5:3)
  - 4→(pin[1]?0:5)
  - 5→0
- R3: With `tmode`=1 and `hold`=0, each rising clock loads the sequencer code. After reset the sequence is 6, then 7, and it then stays at 7.
- R4: With `hold`=1, the state register keeps its value and the sequencer does not step, whatever `tmode` and `pin` are.
- R5: `st_obs` equals the present state in every cycle.
- R6: `pout` equals present-state bits [1:0] XOR `pin` in both modes.
- R7: `st_par` equals the XOR of all `st_obs` bits (parameter PAR_EN=1, the default).
- R8: The normal next-state logic also handles the unreachable codes: from 6 or 7 with `tmode`=0, the next state is 1 if pin[0] is 1, else 0.
- R9: The sequencer steps only on cycles with `tmode`=1 and `hold`=0. Interleaved normal-mode cycles leave its position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin | input | 2 | Primary inputs |
| tmode | input | 1 | 1 selects the test sequencer as the register source |
| hold | input | 1 | 1 freezes the state register |
| pout | output | 2 | Primary outputs |
| st_obs | output | 3 | Present-state observation bus |
| st_par | output | 1 | Parity of the observation bus |

## Verification
The interesting collision is between `hold` and `tmode`: both can be high in the same cycle, and only one of them may take effect. The bench raises both together while the sequencer is mid-sequence. It then judges the outcome on two counts: the state must stay put, and the next pure test cycle must still yield the code that was pending. A second overlap mixes normal and test cycles. A normal step from an unreachable code must land on a reachable state, and the following test cycle must continue the sequence where it stopped.

// File: rtl/ctl_dft_pkg.sv
package ctl_dft_pkg;
  localparam int ST_W      = 3;
  localparam int PI_W      = 2;
  localparam int PO_W      = 2;
  localparam int NUM_VALID = 6;
  localparam logic [ST_W-1:0] RST_CODE = '0;

  typedef enum logic [1:0] {SEL_NORMAL, SEL_TEST, SEL_HOLD} load_sel_e;

  // normal next-state function of the controller
  function automatic logic [ST_W-1:0] next_code(input logic [ST_W-1:0] s,
                                                input logic [PI_W-1:0] x);
    logic [ST_W-1:0] n;
    case (s)
      3'd0:    n = x[0] ? 3'd1 : 3'd0;
      3'd1:    n = x[1] ? 3'd2 : 3'd3;
      3'd2:    n = 3'd4;
      3'd3:    n = x[0] ? 3'd5 : 3'd3;
      3'd4:    n = x[1] ? 3'd0 : 3'd5;
      3'd5:    n = 3'd0;
      default: n = x[0] ? 3'd1 : 3'd0;
    endcase
    return n;
  endfunction

  function automatic logic [PO_W-1:0] out_code(input logic [ST_W-1:0] s,
                                               input logic [PI_W-1:0] x);
    return s[PO_W-1:0] ^ x;
  endfunction
endpackage

// File: rtl/ctl_next_logic.sv
module ctl_next_logic
  import ctl_dft_pkg::*;
(
  input  logic [ST_W-1:0] cur,
  input  logic [PI_W-1:0] x,
  output logic [ST_W-1:0] nxt,
  output logic [PO_W-1:0] y
);
  always_comb begin
    nxt = next_code(cur, x);
    y   = out_code(cur, x);
  end
endmodule

// File: rtl/inv_state_gen.sv
module inv_state_gen #(
  parameter int ST_W      = 3,
  parameter int NUM_VALID = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [ST_W-1:0] code
);
  localparam int NUM_INV = (1 << ST_W) - NUM_VALID;
  localparam int POS_W   = (NUM_INV > 1) ? $clog2(NUM_INV) : 1;
  localparam logic [POS_W-1:0] LAST = POS_W'(NUM_INV - 1);

  logic [POS_W-1:0] pos;
  logic             at_last;

  assign at_last = (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (adv && !at_last)
      pos <= pos + 1'b1;
  end

  assign code = ST_W'(NUM_VALID) + ST_W'(pos);
endmodule

// File: rtl/state_hold_reg.sv
module state_hold_reg
  import ctl_dft_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  load_sel_e       sel,
  input  logic [ST_W-1:0] nxt,
  input  logic [ST_W-1:0] gen,
  output logic [ST_W-1:0] q
);
  logic [ST_W-1:0] d;

  always_comb begin
    case (sel)
      SEL_TEST: d = gen;
      SEL_HOLD: d = q;
      default:  d = nxt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_CODE;
    else        q <= d;
  end
endmodule

// File: rtl/ctl_dft_top.sv
module ctl_dft_top
  import ctl_dft_pkg::*;
#(
  parameter bit PAR_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PI_W-1:0] pin,
  input  logic            tmode,
  input  logic            hold,
  output logic [PO_W-1:0] pout,
  output logic [ST_W-1:0] st_obs,
  output logic            st_par
);
  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] nxt_code;
  logic [ST_W-1:0] gen_code;
  load_sel_e       sel;
  logic            gen_step;

  always_comb begin
    if (hold)       sel = SEL_HOLD;
    else if (tmode) sel = SEL_TEST;
    else            sel = SEL_NORMAL;
  end
  assign gen_step = (sel == SEL_TEST);

  ctl_next_logic u_logic (.cur(state_q), .x(pin), .nxt(nxt_code), .y(pout));

  inv_state_gen #(.ST_W(ST_W), .NUM_VALID(NUM_VALID)) u_gen (
    .clk(clk), .rst_n(rst_n), .adv(gen_step), .code(gen_code));

  state_hold_reg u_reg (.clk(clk), .rst_n(rst_n), .sel(sel),
                        .nxt(nxt_code), .gen(gen_code), .q(state_q));

  assign st_obs = state_q;

  generate
    if (PAR_EN) begin : g_par
      assign st_par = ^state_q;
    end else begin : g_nopar
      assign st_par = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ctl_dft_chk.sv
module ctl_dft_chk
  import ctl_dft_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            tmode,
  input logic            hold,
  input logic [ST_W-1:0] st_obs,
  input logic [ST_W-1:0] nxt_code,
  input logic [ST_W-1:0] gen_code
);
  AST_NORMAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !tmode) |=> (st_obs == $past(nxt_code))); // R2

  AST_TEST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && tmode) |=> (st_obs == $past(gen_code))); // R3

  AST_GEN_UNREACHABLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_code >= ST_W'(NUM_VALID)); // R3

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(st_obs)); // R4

  AST_GEN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || !tmode) |=> $stable(gen_code)); // R9
endmodule

bind ctl_dft_top ctl_dft_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tmode(tmode), .hold(hold),
  .st_obs(st_obs), .nxt_code(nxt_code), .gen_code(gen_code));

// File: tb/test_ctl_dft_top.sv
module test_ctl_dft_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin = '0;
  logic       tmode = 1'b0;
  logic       hold = 1'b0;
  logic [1:0] pout;
  logic [2:0] st_obs;
  logic       st_par;

  ctl_dft_top i_ctl_dft_top (.clk(clk), .rst_n(rst_n), .pin(pin), .tmode(tmode),
                             .hold(hold), .pout(pout), .st_obs(st_obs), .st_par(st_par));

  always #2 clk = ~clk;

  typedef struct {
    logic [2:0] st;
    logic [1:0] po;
    logic       par;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic [2:0] m_st;
  int         m_pos;
  bit         done = 0;

  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic [1:0] x);
    unique case (s)
      3'd0: return x[0] ? 3'd1 : 3'd0;
      3'd1: return x[1] ? 3'd2 : 3'd3;
      3'd2: return 3'd4;
      3'd3: return x[0] ? 3'd5 : 3'd3;
      3'd4: return x[1] ? 3'd0 : 3'd5;
      3'd5: return 3'd0;
      default: return x[0] ? 3'd1 : 3'd0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tmode = 0; hold = 0; pin = 0;
    m_st = 3'd0; m_pos = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one cycle, push the expected present-state view, then advance the model
  task automatic step(input bit t, input bit h, input logic [1:0] x, input string tag);
    exp_t e;
    @(negedge clk);
    tmode = t; hold = h; pin = x;
    #1;
    e.st = m_st; e.po = m_st[1:0] ^ x; e.par = ^m_st; e.tag = tag;
    q.push_back(e);
    if (!h) begin
      if (t) begin
        m_st = 3'(6 + m_pos);
        if (m_pos < 1) m_pos++;
      end else m_st = ref_next(m_st, x);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      checks++;
      if (st_obs !== e.st || pout !== e.po || st_par !== e.par) begin
        errors++;
        $display("FAIL %s: st_obs=%0d pout=%0d st_par=%0d expected %0d %0d %0d",
                 e.tag, st_obs, pout, st_par, e.st, e.po, e.par);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    do_reset();
    step(0, 0, 2'd0, "R1 reset state");
    // R2 / R6 normal walk through every reachable state
    step(0, 0, 2'd1, "R2 s0->s1");
    step(0, 0, 2'd2, "R2 s1->s2");
    step(0, 0, 2'd3, "R6 s2->s4");
    step(0, 0, 2'd2, "R2 s4->s0");
    step(0, 0, 2'd1, "R2 s0->s1");
    step(0, 0, 2'd0, "R2 s1->s3");
    step(0, 0, 2'd0, "R2 s3 stays");
    step(0, 0, 2'd1, "R2 s3->s5");
    step(0, 0, 2'd3, "R5 s5->s0");
    step(0, 0, 2'd1, "R2 s0->s1");
    // R4 hold, also with tmode high at once
    step(0, 1, 2'd2, "R4 hold normal");
    step(1, 1, 2'd3, "R4 hold with tmode");
    step(0, 0, 2'd0, "R4 value kept");
    // R3 sequence from reset
    do_reset();
    step(1, 0, 2'd0, "R3 load first code");
    step(1, 1, 2'd1, "R4 hold mid sequence");
    step(1, 0, 2'd3, "R3 state 6");
    step(1, 0, 2'd0, "R3 state 7");
    step(0, 0, 2'd1, "R7 parity at 7 stays");
    // R8 from 7 normal step lands on 1
    step(0, 0, 2'd0, "R8 reached from 7");
    // R9 interleave
    do_reset();
    step(1, 0, 2'd0, "R9 first test load");
    step(0, 0, 2'd1, "R8 from 6 with pin0");
    step(1, 0, 2'd2, "R9 normal step between");
    step(0, 0, 2'd0, "R9 continues at 7");
    // R1 mid-run reset restarts sequencer
    step(1, 0, 2'd0, "R1 before reset");
    do_reset();
    step(1, 0, 2'd2, "R1 after reset");
    step(0, 0, 2'd0, "R1 sequencer restarted at 6");
    step(0, 0, 2'd0, "R8 from 6 no pin0");
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule